// File: doc/BRIEF.md
# I2C Configuration Register Controller

This block is an I2C target that owns two small stored configuration words and one output-selection setting. A bus controller addresses it with a fixed five-bit prefix and two strap pins. It then sends a command byte. The command either picks one of the two stored words, picks a live view of five external pins, or forces which source a downstream output stage should use. The two stored words and the chosen selection are presented as plain outputs to that output stage.

Writes are never applied while a transfer is in progress. Data bytes are held in a staging area, and both words are updated together when the STOP condition arrives. A write-protect pin blocks any data from being accepted. A third data byte in one transfer throws away the whole transfer. After each committed write the block ignores its own address for a programmable number of clock cycles, which models the time a non-volatile store needs.

SCL and SDA are oversampled by the system clock. The block drives SDA only through a pull-low output; the bus itself is open drain.

Top module: `i2c_cfg_ctrl`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1,0,0,1,1 followed by `addr_pins_i[1]` and `addr_pins_i[0]`. Bit 0 of the address byte selects the direction, with 1 meaning read. Any other address is not acknowledged.
- R2: The following command bytes are acknowledged: 0x00, 0x01, 0xFF, and every byte whose upper five bits are 11111. All other command bytes are not acknowledged and change nothing.
- R3: Data written after a register command is held until the next STOP. Only bits 5:0 of each byte are stored, and bits 7:6 are ignored.
- R4: Within one write, the first data byte goes to the register the command named (0x00 selects word 0, 0x01 selects word 1). The second data byte goes to the other register.
- R5: A third data byte in one write is not acknowledged. The following STOP then leaves both registers unchanged.
- R6: While `wp_i`=1, the address and the command are acknowledged, data bytes are not acknowledged, and neither register changes.
- R7: Override commands set `ovr_sel_o` as follows:
  - 11111000 sets code 1 (word 0).
  - 11111100 sets code 2 (word 1).
  - 11111x10 sets code 3 (external pins).
  - 11111xx1, other than 0xFF, sets code 0 (follow the select pins).
  - Data bytes sent after an override command are not acknowledged.
- R8: For `BUSY_CYCLES` clock cycles after a committed write, the block does not acknowledge its own address. Once that time has passed, it acknowledges its address again.
- R9: Read data depends on the stored command:
  - After a register command, the byte is {2'b00, word}.
  - After 0xFF, the byte is {3'b000, `pins_i[4:0]`}.
  - After an override command, the byte is 0x00.
- R10: Every register byte that is read or accepted for writing moves the word pointer to the other word, so consecutive read bytes alternate between word 0 and word 1.
- R11: A repeated START keeps the stored command and discards any staged write data.
- R12: After reset, both words are 0, `ovr_sel_o` is 0, and `sda_pull_o` is 0. The stored command is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_pins_i | input | 2 | Strap bits forming the low address bits |
| wp_i | input | 1 | 1 blocks all register writes |
| pins_i | input | 5 | External pin values for the snapshot read |
| reg0_o | output | 6 | Stored configuration word 0 |
| reg1_o | output | 6 | Stored configuration word 1 |
| ovr_sel_o | output | 2 | Output-source override code |

## Verification
The hardest state to reach from the ports is the busy window. The only way to enter it is a complete write that ends in a STOP. The only way to see it is to attempt a fresh address phase before the window closes. The stimulus therefore runs with a short busy length. It issues a committed write and, immediately after it, a START and address. It expects no acknowledge. It then waits out the window and expects the acknowledge to return. The cancelled three-byte write and the repeated START that drops staged data are also driven back to back with reads. This shows, through the normal read path, that nothing reached the stored words.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  parameter int unsigned CFG_BITS = 6;
  parameter int unsigned PIN_BITS = 5;
  parameter int unsigned BYTE_BITS = 8;
  parameter logic [4:0] DEV_PREFIX = 5'b10011;

  typedef enum logic [1:0] {
    SEL_FOLLOW = 2'd0,
    SEL_WORD0  = 2'd1,
    SEL_WORD1  = 2'd2,
    SEL_EXT    = 2'd3
  } out_sel_e;

  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_REG  = 2'd1,
    CK_SNAP = 2'd2,
    CK_OVR  = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    logic      idx;
    out_sel_e  sel;
  } cmd_dec_t;

  // Classify a command byte.
  // 0xFF wins over the 11111xx1 override pattern.
  function automatic cmd_dec_t decode_cmd(input logic [BYTE_BITS-1:0] c);
    cmd_dec_t d;
    d.kind = CK_NONE;
    d.idx  = c[0];
    d.sel  = SEL_FOLLOW;
    if (c[7:1] == 7'd0) begin
      d.kind = CK_REG;
    end else if (c == 8'hFF) begin
      d.kind = CK_SNAP;
    end else if (c[7:3] == 5'b11111) begin
      d.kind = CK_OVR;
      if (c[0])      d.sel = SEL_FOLLOW;
      else if (c[1]) d.sel = SEL_EXT;
      else if (c[2]) d.sel = SEL_WORD1;
      else           d.sel = SEL_WORD0;
    end
    return d;
  endfunction

  // Build the byte returned on a read.
  function automatic logic [BYTE_BITS-1:0] read_byte(
    input cmd_kind_e           kind,
    input logic                ptr,
    input logic [CFG_BITS-1:0] w0,
    input logic [CFG_BITS-1:0] w1,
    input logic [PIN_BITS-1:0] pins
  );
    logic [BYTE_BITS-1:0] b;
    b = '0;
    case (kind)
      CK_REG:  b[CFG_BITS-1:0] = ptr ? w1 : w0;
      CK_SNAP: b[PIN_BITS-1:0] = pins;
      default: b = '0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh;
  logic [DEPTH-1:0] sda_sh;
  logic scl_now;
  logic scl_old;
  logic sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  assign scl_now   = scl_sh[STAGES-1];
  assign scl_old   = scl_sh[STAGES];
  assign sda_s     = sda_sh[STAGES-1];
  assign sda_old   = sda_sh[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_evt = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_evt  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned REG_W       = CFG_BITS,
  parameter int unsigned BUSY_CYCLES = 900_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stage_we,
  input  logic             stage_idx,
  input  logic [REG_W-1:0] stage_dat,
  input  logic             stage_drop,
  input  logic             commit_req,
  output logic [REG_W-1:0] reg0_o,
  output logic [REG_W-1:0] reg1_o,
  output logic             busy_o,
  output logic             commit_evt
);
  localparam int unsigned NREG = 2;
  localparam int unsigned CW   = $clog2(BUSY_CYCLES + 1);

  logic [REG_W-1:0] word_q [NREG];
  logic [REG_W-1:0] stg_q  [NREG];
  logic [NREG-1:0]  stg_val;
  logic [CW-1:0]    busy_cnt;

  assign commit_evt = commit_req & (|stg_val);

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g]  <= '0;
        stg_q[g]   <= '0;
        stg_val[g] <= 1'b0;
      end else if (commit_evt) begin
        if (stg_val[g]) word_q[g] <= stg_q[g];
        stg_val[g] <= 1'b0;
      end else if (stage_drop) begin
        stg_val[g] <= 1'b0;
      end else if (stage_we && (stage_idx == 1'(g))) begin
        stg_q[g]   <= stage_dat;
        stg_val[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busy_cnt <= '0;
    else if (commit_evt)      busy_cnt <= CW'(BUSY_CYCLES);
    else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy_o = (busy_cnt != '0);
  assign reg0_o = word_q[0];
  assign reg1_o = word_q[1];
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import i2c_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_evt,
  input  logic                stop_evt,
  input  logic [1:0]          addr_pins_i,
  input  logic                wp_i,
  input  logic [PIN_BITS-1:0] pins_i,
  input  logic [CFG_BITS-1:0] reg0_i,
  input  logic [CFG_BITS-1:0] reg1_i,
  input  logic                busy_i,
  output logic                sda_pull_o,
  output logic                stage_we,
  output logic                stage_idx,
  output logic [CFG_BITS-1:0] stage_dat,
  output logic                stage_drop,
  output logic                commit_req,
  output out_sel_e            ovr_sel_o,
  output logic                addr_ack_evt
);
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_DACK, S_TX, S_MACK
  } st_e;

  st_e                  st;
  logic [BYTE_BITS-1:0] rx;
  logic [BYTE_BITS-1:0] tx;
  logic [3:0]           nbit;
  logic                 rw;
  cmd_kind_e            kind;
  logic                 ptr;
  logic [1:0]           ndat;
  logic                 macked;
  logic                 pull;
  out_sel_e             sel;

  cmd_dec_t             dec;
  logic                 byte_done;
  logic                 receiving;
  logic                 addr_hit;
  logic                 cmd_ok;
  logic                 data_ok;
  logic                 data_cancel;
  logic [BYTE_BITS-1:0] rd_val;

  assign dec         = decode_cmd(rx);
  assign byte_done   = scl_fall && (nbit == 4'd8);
  assign receiving   = (st == S_ADDR) || (st == S_CMD) || (st == S_WDAT);
  assign addr_hit    = (rx[7:1] == {DEV_PREFIX, addr_pins_i});
  assign addr_ack_evt= (st == S_ADDR) && byte_done && addr_hit && !busy_i;
  assign cmd_ok      = (st == S_CMD) && byte_done && (dec.kind != CK_NONE);
  assign data_ok     = (st == S_WDAT) && byte_done && (kind == CK_REG) && !wp_i && (ndat < 2'd2);
  assign data_cancel = (st == S_WDAT) && byte_done && (kind == CK_REG) && !wp_i && (ndat == 2'd2);
  assign rd_val      = read_byte(kind, ptr, reg0_i, reg1_i, pins_i);

  assign stage_we    = data_ok;
  assign stage_idx   = ptr;
  assign stage_dat   = rx[CFG_BITS-1:0];
  assign stage_drop  = start_evt | data_cancel;
  assign commit_req  = stop_evt;
  assign sda_pull_o  = pull;
  assign ovr_sel_o   = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rx     <= '0;
      tx     <= '0;
      nbit   <= '0;
      rw     <= 1'b0;
      kind   <= CK_REG;
      ptr    <= 1'b0;
      ndat   <= '0;
      macked <= 1'b0;
      pull   <= 1'b0;
      sel    <= SEL_FOLLOW;
    end else if (start_evt) begin
      st   <= S_ADDR;
      nbit <= '0;
      pull <= 1'b0;
    end else if (stop_evt) begin
      st   <= S_IDLE;
      pull <= 1'b0;
    end else begin
      if (receiving && scl_rise && (nbit < 4'd8)) begin
        rx   <= {rx[BYTE_BITS-2:0], sda_s};
        nbit <= nbit + 4'd1;
      end
      case (st)
        S_ADDR: if (byte_done) begin
          if (addr_ack_evt) begin
            st   <= S_AACK;
            pull <= 1'b1;
            rw   <= rx[0];
          end else begin
            st <= S_IDLE;
          end
        end
        S_AACK: if (scl_fall) begin
          nbit <= '0;
          if (rw) begin
            st     <= S_TX;
            tx     <= rd_val;
            pull   <= ~rd_val[BYTE_BITS-1];
            macked <= 1'b0;
            if (kind == CK_REG) ptr <= ~ptr;
          end else begin
            st   <= S_CMD;
            pull <= 1'b0;
          end
        end
        S_CMD: if (byte_done) begin
          if (cmd_ok) begin
            kind <= dec.kind;
            if (dec.kind == CK_REG) ptr <= dec.idx;
            if (dec.kind == CK_OVR) sel <= dec.sel;
            ndat <= '0;
            pull <= 1'b1;
            st   <= S_CACK;
          end else begin
            st <= S_IDLE;
          end
        end
        S_CACK, S_DACK: if (scl_fall) begin
          pull <= 1'b0;
          nbit <= '0;
          st   <= S_WDAT;
        end
        S_WDAT: if (byte_done) begin
          if (data_ok) begin
            pull <= 1'b1;
            ptr  <= ~ptr;
            ndat <= ndat + 2'd1;
            st   <= S_DACK;
          end else begin
            st <= S_IDLE;
          end
        end
        S_TX: if (scl_fall) begin
          if (nbit == 4'd7) begin
            st   <= S_MACK;
            pull <= 1'b0;
          end else begin
            tx   <= {tx[BYTE_BITS-2:0], 1'b0};
            pull <= ~tx[BYTE_BITS-2];
            nbit <= nbit + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) macked <= ~sda_s;
          if (scl_fall) begin
            if (macked) begin
              st     <= S_TX;
              tx     <= rd_val;
              pull   <= ~rd_val[BYTE_BITS-1];
              nbit   <= '0;
              macked <= 1'b0;
              if (kind == CK_REG) ptr <= ~ptr;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 900_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  input  logic [1:0]          addr_pins_i,
  input  logic                wp_i,
  input  logic [PIN_BITS-1:0] pins_i,
  output logic [CFG_BITS-1:0] reg0_o,
  output logic [CFG_BITS-1:0] reg1_o,
  output logic [1:0]          ovr_sel_o
);
  logic                sda_s_w;
  logic                scl_rise_w;
  logic                scl_fall_w;
  logic                start_w;
  logic                stop_w;
  logic                stage_we_w;
  logic                stage_idx_w;
  logic [CFG_BITS-1:0] stage_dat_w;
  logic                stage_drop_w;
  logic                commit_req_w;
  logic                commit_w;
  logic                busy_w;
  logic                addr_ack_w;
  out_sel_e            sel_w;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s_w),
    .scl_rise (scl_rise_w),
    .scl_fall (scl_fall_w),
    .start_evt(start_w),
    .stop_evt (stop_w)
  );

  i2c_cfg_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_s       (sda_s_w),
    .scl_rise    (scl_rise_w),
    .scl_fall    (scl_fall_w),
    .start_evt   (start_w),
    .stop_evt    (stop_w),
    .addr_pins_i (addr_pins_i),
    .wp_i        (wp_i),
    .pins_i      (pins_i),
    .reg0_i      (reg0_o),
    .reg1_i      (reg1_o),
    .busy_i      (busy_w),
    .sda_pull_o  (sda_pull_o),
    .stage_we    (stage_we_w),
    .stage_idx   (stage_idx_w),
    .stage_dat   (stage_dat_w),
    .stage_drop  (stage_drop_w),
    .commit_req  (commit_req_w),
    .ovr_sel_o   (sel_w),
    .addr_ack_evt(addr_ack_w)
  );

  cfg_reg_bank #(.REG_W(CFG_BITS), .BUSY_CYCLES(BUSY_CYCLES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .stage_we  (stage_we_w),
    .stage_idx (stage_idx_w),
    .stage_dat (stage_dat_w),
    .stage_drop(stage_drop_w),
    .commit_req(commit_req_w),
    .reg0_o    (reg0_o),
    .reg1_o    (reg1_o),
    .busy_o    (busy_w),
    .commit_evt(commit_w)
  );

  assign ovr_sel_o = sel_w;
endmodule

// File: rtl/i2c_cfg_checker.sv
module i2c_cfg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic [5:0] reg0,
  input logic [5:0] reg1,
  input logic [1:0] ovr_sel,
  input logic       commit_evt,
  input logic       busy,
  input logic       addr_ack,
  input logic       scl_fall,
  input logic       start_evt,
  input logic       stop_evt
);
  // R3: stored words change only right after a commit
  p_word0_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg0) |-> $past(commit_evt));
  p_word1_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg1) |-> $past(commit_evt));
  // R8: a commit opens the busy window
  p_busy_after_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> busy);
  // R8: no write can be committed while busy, since the address was refused
  p_commit_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> !busy);
  // R8: address acceptance lies outside the busy window
  p_ack_outside_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |=> !busy);
  // R1: the data line driver only moves on a bus clock fall or a framing event
  p_pull_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_evt || stop_evt));
  // R7: the override changes only at a byte boundary
  p_ovr_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovr_sel) |-> $past(scl_fall));
endmodule

bind i2c_cfg_ctrl i2c_cfg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_pull  (sda_pull_o),
  .reg0      (reg0_o),
  .reg1      (reg1_o),
  .ovr_sel   (ovr_sel_o),
  .commit_evt(commit_w),
  .busy      (busy_w),
  .addr_ack  (addr_ack_w),
  .scl_fall  (scl_fall_w),
  .start_evt (start_w),
  .stop_evt  (stop_w)
);

// File: tb/tb_i2c_cfg_ctrl.sv
module tb_i2c_cfg_ctrl;
  localparam int BUSY = 400;
  localparam int Q    = 10;
  localparam logic [7:0] AW = 8'h9C;  // 10011,10,W
  localparam logic [7:0] AR = 8'h9D;
  localparam logic [7:0] AX = 8'h9E;  // wrong straps

  // {cmd, expected ack, expected override code}
  localparam logic [10:0] OVR_VEC [10] = '{
    {8'hF8, 1'b1, 2'd1}, {8'hF9, 1'b1, 2'd0}, {8'hFA, 1'b1, 2'd3},
    {8'hFC, 1'b1, 2'd2}, {8'h02, 1'b0, 2'd2}, {8'hFE, 1'b1, 2'd3},
    {8'hF0, 1'b0, 2'd3}, {8'hFD, 1'b1, 2'd0}, {8'h80, 1'b0, 2'd0},
    {8'hFF, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic [4:0] pins = 5'd0;
  logic pull;
  logic [5:0] r0, r1;
  logic [1:0] ovr;
  wire sda_line = m_sda & ~pull;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_cfg_ctrl #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(pull), .addr_pins_i(2'b10), .wp_i(wp), .pins_i(pins),
    .reg0_o(r0), .reg1_o(r1), .ovr_sel_o(ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0;
    end
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q / 2);
    ack = ~sda_line;
    wq(Q - Q / 2); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q / 2);
      b[i] = sda_line;
      wq(Q - Q / 2); scl = 1'b0;
    end
    m_sda = ~mack; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    wq(5);
    // R12: reset state
    chk("R12 reg0", r0, 0); chk("R12 reg1", r1, 0);
    chk("R12 ovr", ovr, 0); chk("R12 pull", pull, 0);
    rst_n = 1'b1; wq(5);
    chk("R12 pull after reset", pull, 0);

    // R12: stored command after reset is 0x00 -> read word 0
    bstart(); send_byte(AR, a); chk("R1 read addr ack", a, 1);
    recv_byte(1'b0, d); bstop();
    chk("R12 initial read", d, 8'h00);

    // R1: wrong address not acknowledged
    bstart(); send_byte(AX, a); bstop();
    chk("R1 wrong addr nack", a, 0);

    // R2/R7: command table
    for (int k = 0; k < 10; k++) begin
      bstart(); send_byte(AW, a);
      send_byte(OVR_VEC[k][10:3], a);
      chk("R2 cmd ack", a, OVR_VEC[k][2]);
      bstop();
      chk("R7 override code", ovr, OVR_VEC[k][1:0]);
    end

    // R3: staged only until STOP, upper bits ignored
    bstart(); send_byte(AW, a); send_byte(8'h00, a);
    send_byte(8'hC5, a); chk("R3 data ack", a, 1);
    chk("R3 not before stop", r0, 0);
    bstop();
    chk("R3 committed low bits", r0, 6'h05);
    // R8: immediately addressed -> refused
    bstart(); send_byte(AW, a); bstop();
    chk("R8 busy nack", a, 0);
    wq(BUSY + 100);
    bstart(); send_byte(AW, a); bstop();
    chk("R8 ack after busy", a, 1);

    // R4: two bytes, pointed then other
    bstart(); send_byte(AW, a); send_byte(8'h01, a);
    send_byte(8'h2A, a); send_byte(8'h3F, a); bstop();
    chk("R4 word1", r1, 6'h2A); chk("R4 word0", r0, 6'h3F);
    wq(BUSY + 100);

    // R5: third byte cancels
    bstart(); send_byte(AW, a); send_byte(8'h00, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk("R5 third nack", a, 0);
    bstop();
    chk("R5 word0 kept", r0, 6'h3F); chk("R5 word1 kept", r1, 6'h2A);

    // R6: write protect
    wp = 1'b1;
    bstart(); send_byte(AW, a); chk("R6 addr ack", a, 1);
    send_byte(8'h01, a); chk("R6 cmd ack", a, 1);
    send_byte(8'h07, a); chk("R6 data nack", a, 0);
    bstop(); wp = 1'b0;
    chk("R6 word1 kept", r1, 6'h2A);

    // R9/R10: register read alternates
    bstart(); send_byte(AW, a); send_byte(8'h00, a);
    bstart(); send_byte(AR, a);
    recv_byte(1'b1, d); chk("R9 read word0", d, 8'h3F);
    recv_byte(1'b1, d); chk("R10 read alternates", d, 8'h2A);
    recv_byte(1'b0, d); chk("R10 read wraps", d, 8'h3F);
    bstop();

    // R9: pin snapshot
    pins = 5'b10110;
    bstart(); send_byte(AW, a); send_byte(8'hFF, a);
    bstart(); send_byte(AR, a); recv_byte(1'b0, d); bstop();
    chk("R9 pin snapshot", d, 8'h16);

    // R11: repeated START drops staged data, keeps command
    bstart(); send_byte(AW, a); send_byte(8'h01, a); send_byte(8'h15, a);
    bstart(); send_byte(AR, a); recv_byte(1'b0, d); bstop();
    chk("R11 read after Sr", d, 8'h3F);
    chk("R11 word1 kept", r1, 6'h2A);

    // R7/R9: data after override not acked, read gives zero
    bstart(); send_byte(AW, a); send_byte(8'hF8, a);
    send_byte(8'h01, a); chk("R7 data after override nack", a, 0);
    bstop();
    bstart(); send_byte(AR, a); recv_byte(1'b0, d); bstop();
    chk("R9 override read zero", d, 8'h00);
    chk("R7 override held", ovr, 2'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule